// File: doc/BRIEF.md
# Prescaled Fan PWM Generator

This block drives one fan-control PWM pin from the system clock. A two-stage prescaler turns the system clock into a slower count tick. An 8-bit period counter advances on each tick and runs from 0 up to a programmed period value, then wraps. Two compare points, a rise point and a fall point, set where the pin goes high and where it goes low within each period, so the pulse can sit anywhere in the cycle.

The controller supplies fields that are already resolved: a packed clock-control word, the two compare points and an enable. To turn a fan off, the controller clears the enable; it does not write a zero-width compare. When the on-time equals the whole period, the fall point is written as 0, and the pin then stays high for the entire cycle. New settings are captured only when a cycle starts, so writes made during a cycle cannot produce a runt pulse. A one-clock strobe marks each wrap of the period counter.

Top module: `fan_pwm_gen`

## Requirements
- R1: The clock-control word holds the period value P in bits [15:8], the high divider field H in bits [7:4] and the low divider field L in bits [3:0].
- R2: The high prescaler stage divides the clock by 2 to the power H.
- R3: The low prescaler stage divides by 1 when L is 0, and by 2*L otherwise.
- R4: One PWM cycle lasts exactly 2^H * Ldiv * (P+1) clocks, and the period counter takes each value 0..P for 2^H * Ldiv clocks.
- R5: When rise < fall, the pin is high while the counter value c satisfies rise <= c < fall, and low otherwise.
- R6: When the fall point is 0, the pin is high for every clock of every cycle while the block is enabled, whatever the rise point is.
- R7: When rise equals fall and both are nonzero, the pin stays low.
- R8: When rise > fall and fall is nonzero, the pin is high for c >= rise or c < fall, so the pulse wraps across the cycle boundary.
- R9: When the enable is low at a clock edge, the pin is low and the counters are at zero after that edge. The first edge with the enable high starts a cycle at count 0 and uses the inputs present at that edge.
- R10: While a cycle runs, changes to the clock-control word and the compare points have no effect until the next wrap. At the wrap they apply together.
- R11: The cycle-start output is high for exactly the one clock that follows each wrap of the period counter to zero. It is not asserted when the block is first enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; low forces the pin low and clears the counters |
| clk_ctrl_i | input | 16 | Period [15:8], high divider [7:4], low divider [3:0] |
| rise_i | input | 8 | Counter value at which the pin goes high |
| fall_i | input | 8 | Counter value at which the pin goes low; 0 means high for the whole cycle |
| pwm_o | output | 1 | PWM pin |
| cyc_start_o | output | 1 | One-clock strobe after each wrap of the period counter |

## Verification
The critical overlap is a settings write landing in the same clock as a period wrap, or part way through a cycle just before one. In that case the capture of new values and the closing of the current cycle must both resolve at one edge. The bench changes the clock-control word and the compare points at random clock offsets during running cycles, sometimes on the wrap clock itself. It checks that the pin level and the strobe follow the old settings until the wrap and the new settings from the first clock after it. Enable drops of one to three clocks inside a cycle are also mixed in, to confirm that the restart captures inputs and emits no strobe.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  localparam int LVL_W = 16;

  // pin level for counter value c, given compare points r and f
  function automatic logic duty_level(logic [LVL_W-1:0] c,
                                      logic [LVL_W-1:0] r,
                                      logic [LVL_W-1:0] f);
    logic lvl;
    if (f == '0)      lvl = 1'b1;
    else if (r == f)  lvl = 1'b0;
    else if (r < f)   lvl = (c >= r) && (c < f);
    else              lvl = (c >= r) || (c < f);
    return lvl;
  endfunction

endpackage

// File: rtl/fpwm_shadow.sv
module fpwm_shadow #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/fpwm_prescale.sv
module fpwm_prescale #(
  parameter int HDIV_W = 4,
  parameter int LDIV_W = 4,
  localparam int H1_W  = (1 << HDIV_W) - 1,
  localparam int L2_W  = LDIV_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [HDIV_W-1:0] hdiv_i,
  input  logic [LDIV_W-1:0] ldiv_i,
  output logic              tick_o
);

  logic [H1_W-1:0] c1_q;
  logic [L2_W-1:0] c2_q;
  logic [H1_W:0]   h_pow;
  logic [H1_W:0]   h_full;
  logic [H1_W-1:0] h_max;
  logic [L2_W-1:0] l_max;
  logic            t1;

  assign h_pow  = (H1_W+1)'(1) << hdiv_i;
  assign h_full = h_pow - (H1_W+1)'(1);
  assign h_max  = h_full[H1_W-1:0];
  assign l_max  = (ldiv_i == '0) ? '0 : ({ldiv_i, 1'b0} - L2_W'(1));

  assign t1     = (c1_q == h_max);
  assign tick_o = act_i && t1 && (c2_q == l_max);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= '0;
      c2_q <= '0;
    end else if (!act_i) begin
      c1_q <= '0;
      c2_q <= '0;
    end else begin
      c1_q <= t1 ? '0 : c1_q + H1_W'(1);
      if (t1) c2_q <= (c2_q == l_max) ? '0 : c2_q + L2_W'(1);
    end
  end

  a_r2_high_stage_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c1_q <= h_max);

  a_r3_low_stage_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c2_q <= l_max);

endmodule

// File: rtl/fpwm_period.sv
module fpwm_period #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             cyc_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             cyc_q;

  assign wrap_o = act_i && tick_i && (cnt_q == per_i);
  assign cnt_o  = cnt_q;
  assign cyc_o  = cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cyc_q <= 1'b0;
    end else begin
      cyc_q <= wrap_o;
      if (!act_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_i);

  a_r11_strobe_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q |-> (cnt_q == '0));

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int CNT_W  = 8,
  parameter int HDIV_W = 4,
  parameter int LDIV_W = 4,
  localparam int CW    = CNT_W + HDIV_W + LDIV_W,
  localparam int SW    = CW + 2 * CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CW-1:0]    clk_ctrl_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic [CNT_W-1:0] fall_i,
  output logic             pwm_o,
  output logic             cyc_start_o
);

  logic             run_q;
  logic             act;
  logic             load;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic [SW-1:0]    sh;
  logic [CW-1:0]    word_sh;
  logic [CNT_W-1:0] rise_sh;
  logic [CNT_W-1:0] fall_sh;
  logic [CNT_W-1:0] per_sh;
  logic [HDIV_W-1:0] hdiv_sh;
  logic [LDIV_W-1:0] ldiv_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  assign act  = en_i && run_q;
  // capture while idle (so enable uses current inputs) and at each wrap
  assign load = !run_q || wrap;

  fpwm_shadow #(.W(SW)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    ({clk_ctrl_i, rise_i, fall_i}),
    .q_o    (sh)
  );

  assign word_sh = sh[SW-1 -: CW];
  assign rise_sh = sh[2*CNT_W-1 -: CNT_W];
  assign fall_sh = sh[CNT_W-1:0];
  assign per_sh  = word_sh[CW-1 -: CNT_W];
  assign hdiv_sh = word_sh[LDIV_W+HDIV_W-1 -: HDIV_W];
  assign ldiv_sh = word_sh[LDIV_W-1:0];

  fpwm_prescale #(.HDIV_W(HDIV_W), .LDIV_W(LDIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .hdiv_i (hdiv_sh),
    .ldiv_i (ldiv_sh),
    .tick_o (tick)
  );

  fpwm_period #(.CNT_W(CNT_W)) u_per (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .tick_i (tick),
    .per_i  (per_sh),
    .cnt_o  (cnt),
    .wrap_o (wrap),
    .cyc_o  (cyc_start_o)
  );

  assign pwm_o = run_q && fpwm_pkg::duty_level(fpwm_pkg::LVL_W'(cnt),
                                               fpwm_pkg::LVL_W'(rise_sh),
                                               fpwm_pkg::LVL_W'(fall_sh));

  a_r9_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);

  a_r9_off_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !cyc_start_o);

  a_r10_mid_cycle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !cyc_start_o) |-> $stable(sh));

endmodule

// File: tb/sim_fan_pwm_gen.sv
module sim_fan_pwm_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] word = '0;
  logic [7:0]  rise = '0;
  logic [7:0]  fall = '0;
  logic        pwm;
  logic        cyc;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  bit    m_run = 1'b0;
  bit    m_first = 1'b0;
  int    m_k = 0;
  int    s_per = 0, s_h = 0, s_l = 0, s_r = 0, s_f = 0;
  string ptag = "";

  always #10 clk = ~clk;

  fan_pwm_gen u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .clk_ctrl_i  (word),
    .rise_i      (rise),
    .fall_i      (fall),
    .pwm_o       (pwm),
    .cyc_start_o (cyc)
  );

  function automatic int ddiv(int h, int l);
    return (1 << h) * ((l == 0) ? 1 : 2 * l);
  endfunction

  function automatic int exp_lvl(int c, int r, int f);
    if (f == 0) return 1;
    if (r == f) return 0;
    if (r < f)  return (c >= r && c < f) ? 1 : 0;
    return (c >= r || c < f) ? 1 : 0;
  endfunction

  function automatic string lvl_tag();
    if (s_f == 0)   return "R6";
    if (s_r == s_f) return "R7";
    if (s_r > s_f)  return "R8";
    return "R5";
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // R1: field layout of the clock-control word
  task automatic setv(int h, int l, int per, int r, int f);
    word = {8'(per), 4'(h), 4'(l)};
    rise = 8'(r);
    fall = 8'(f);
  endtask

  task automatic load_sh();
    s_per = int'(word[15:8]);
    s_h   = int'(word[7:4]);
    s_l   = int'(word[3:0]);
    s_r   = int'(rise);
    s_f   = int'(fall);
  endtask

  task automatic advance();
    if (!en) begin
      m_run = 1'b0;
    end else if (!m_run) begin
      m_run = 1'b1; m_k = 0; m_first = 1'b1;
      load_sh();
    end else begin
      m_first = 1'b0;
      m_k++;
      if (m_k == ddiv(s_h, s_l) * (s_per + 1)) begin
        m_k = 0;
        load_sh();
      end
    end
  endtask

  task automatic cyc1();
    string t;
    advance();
    @(negedge clk);
    if (!m_run) begin
      chk("R9", int'(pwm), 0, "pin while disabled");
      chk("R9", int'(cyc), 0, "strobe while disabled");
    end else begin
      t = (ptag != "") ? ptag : lvl_tag();
      chk(t, int'(pwm), exp_lvl(m_k / ddiv(s_h, s_l), s_r, s_f), "pin level");
      chk((ptag != "") ? ptag : "R11", int'(cyc),
          (m_k == 0 && !m_first) ? 1 : 0, "cycle strobe");
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc1();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0f4a;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R9", int'(pwm), 0, "pin in reset");
    chk("R11", int'(cyc), 0, "strobe in reset");
    rst_n = 1'b1;
    run(3);

    // R5 basic pulse from 0
    setv(0, 0, 9, 0, 4); en = 1'b1; run(45);
    ptag = "R6"; setv(0, 0, 7, 0, 0); run(40);
    setv(0, 0, 5, 3, 0); run(30);
    ptag = "R7"; setv(0, 0, 7, 3, 3); run(40);
    ptag = "R8"; setv(0, 0, 9, 6, 2); run(45);
    ptag = "R2"; setv(3, 0, 4, 1, 3); run(200);
    setv(4, 0, 1, 0, 1); run(160);
    ptag = "R3"; setv(0, 5, 3, 0, 2); run(200);
    setv(1, 1, 3, 0, 1); run(80);
    ptag = "R4"; setv(0, 0, 255, 0, 128); run(600);
    setv(0, 0, 0, 0, 0); run(10);
    ptag = "R9"; en = 1'b0; run(5);
    setv(0, 0, 5, 0, 3); en = 1'b1; run(30);
    en = 1'b0; run(1); en = 1'b1; run(20);
    ptag = "R10"; setv(2, 0, 9, 0, 5); run(13);
    setv(0, 0, 3, 1, 2); run(3);
    setv(1, 2, 6, 2, 5); run(37);
    setv(0, 1, 4, 4, 1); run(250);

    ptag = "";
    for (int it = 0; it < 60; it++) begin
      int h, l, per, r, f;
      h   = int'($urandom % 3);
      l   = int'($urandom % 4);
      per = int'($urandom % 24);
      r   = int'($urandom % (per + 2));
      f   = ($urandom % 5 == 0) ? 0 : int'($urandom % (per + 2));
      setv(h, l, per, r, f);
      if ($urandom % 6 == 0) begin
        en = 1'b0; run(1 + int'($urandom % 3)); en = 1'b1;
      end
      run(20 + int'($urandom % 300));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule